// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects eight event lines from a storage host controller into sticky status flags and gates them with an eight-bit mask. Both live in one 16-bit interrupt register. The status flags sit in the low byte and the mask in the high byte, with the same bit order in each. A mask bit of 1 blocks its source. One registered interrupt line goes high when any status flag is set and not masked. Software clears status flags by writing ones to them. A separate strobe, raised when the DMA interrupt flag is cleared, drops the two transfer-completion flags and wipes the mask.

A second 16-bit system control register drives two reset pulses: a controller soft reset and a FIFO flush. The FIFO flush is used to recover after a bus error. Each pulse is stretched inside the block to a minimum length in bus clocks, so a short write still gives a reset that is long enough. While the soft reset is active, the status flags and the mask are held at zero. The same register also reports the cable type sensed on an input pin.

Top module: `stor_irq_ctrl`

## Requirements
- R1: After the asynchronous reset, both registers read 0 (apart from the cable bit), and the interrupt, soft reset and FIFO reset outputs are low.
- R2: An event input high at a clock edge sets the matching status bit. Bit 7 is the address error, 6 reached-multiple, 5 device timing, 4 UDMA terminate, 3 timer, 2 bus error, 1 transfer end and 0 host interrupt. The bit stays set after the event drops.
- R3: A write to the interrupt register (select 0) clears each status bit whose wdata bit [7:0] is 1. Status bits written with 0 are unchanged.
- R4: A write to the interrupt register loads wdata[15:8] into the mask. A read returns {mask, status}.
- R5: The interrupt output equals the OR of (status AND NOT mask), delayed by one clock edge after those registers change.
- R6: When an event and a write-one-to-clear of the same bit fall on the same edge, the bit ends set.
- R7: The DMA-clear strobe clears status bits 1 and 0 and zeroes the mask. It also wins over a mask write on the same edge. Status bits 7 to 2 and any event on the same edge are unaffected.
- R8: Writing 1 to system control bit 15 (select 1) raises the soft reset output on the next edge. The output stays high for max(20, h) cycles, where h is the number of cycles the bit was held.
- R9: System control bit 14 drives the FIFO reset output with the same rule and a minimum of 12 cycles.
- R10: While the soft reset output is high, status and mask are forced to 0. Events, DMA-clear and interrupt register writes are ignored.
- R11: System control bit 13 reads the cable input: 1 means a 40-wire cable. Writes to it have no effect, and bits 12 to 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel_i | input | 1 | Register select: 0 interrupt, 1 system control |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the selected register |
| evt_i | input | 8 | Event sources, one per status bit |
| dma_clr_i | input | 1 | DMA interrupt flag clear strobe |
| cable_40w_i | input | 1 | Cable sense, 1 for 40-wire |
| soft_rst_o | output | 1 | Stretched controller soft reset |
| fifo_rst_o | output | 1 | Stretched FIFO reset |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench targets collisions on one edge: an event against its own write-one-to-clear, and an event on bit 0 against the DMA-clear strobe. A design that lets the clear win would lose an interrupt that arrives during service. Reset pulses are measured for a one-cycle write and for a long hold. A design that skips stretching gives a one-cycle reset, and one that ignores the hold cuts a long reset short. During a soft reset the bench drives events and register writes. A leaky design would show nonzero status or a spurious interrupt once the reset ends.

// File: rtl/stor_irq_pkg.sv
package stor_irq_pkg;
  localparam int NSRC         = 8;
  localparam int REG_W        = 16;
  localparam int SYS_SRST_BIT = 15;
  localparam int SYS_FRST_BIT = 14;
  localparam int SYS_CBL_BIT  = 13;
  localparam logic [NSRC-1:0] DMA_CLR_BITS = NSRC'(8'h03);

  typedef enum logic {
    SEL_INT = 1'b0,
    SEL_SYS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int NSRC = 8,
  parameter logic [NSRC-1:0] DCLR_BITS = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_all,
  input  logic [NSRC-1:0] evt,
  input  logic            w1c_en,
  input  logic [NSRC-1:0] w1c_bits,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic            dma_clr,
  output logic [NSRC-1:0] stat_q,
  output logic [NSRC-1:0] mask_q,
  output logic            irq_q
);
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] stat_d;
  logic [NSRC-1:0] mask_d;
  logic            irq_d;

  always_comb begin
    clr_vec = w1c_en ? w1c_bits : '0;
    if (dma_clr) clr_vec = clr_vec | DCLR_BITS;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_comb begin
      if (clr_all)      stat_d[i] = 1'b0;
      else if (evt[i])  stat_d[i] = 1'b1;
      else              stat_d[i] = stat_q[i] & ~clr_vec[i];
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (mask_we) mask_d = mask_wdata;
    if (dma_clr) mask_d = '0;
    if (clr_all) mask_d = '0;
    irq_d = |(stat_q & ~mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/rst_pulse_stretch.sv
module rst_pulse_stretch #(
  parameter int MIN_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic pulse_q
);
  localparam int CW = (MIN_CYC < 2) ? 1 : $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(MIN_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pulse_d;
  logic          cnt_en;

  always_comb begin
    pulse_d = pulse_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (!pulse_q) begin
      if (req) begin
        pulse_d = 1'b1;
        cnt_d   = LOAD;
        cnt_en  = 1'b1;
      end
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end else if (!req) begin
      pulse_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      pulse_q <= pulse_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/stor_irq_ctrl.sv
module stor_irq_ctrl
  import stor_irq_pkg::*;
#(
  parameter int SRST_MIN = 20,
  parameter int FRST_MIN = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel_i,
  input  logic        reg_wr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  input  logic [7:0]  evt_i,
  input  logic        dma_clr_i,
  input  logic        cable_40w_i,
  output logic        soft_rst_o,
  output logic        fifo_rst_o,
  output logic        irq_o
);
  localparam int NRST = 2;

  logic [NSRC-1:0] stat_w;
  logic [NSRC-1:0] mask_w;
  logic            int_we;
  logic            sys_we;
  logic            srst_bit_q, srst_bit_d;
  logic            frst_bit_q, frst_bit_d;
  logic [NRST-1:0] rst_req;
  logic [NRST-1:0] rst_pulse;

  assign int_we = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_INT) && !soft_rst_o;
  assign sys_we = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_SYS);

  irq_stat_bank #(
    .NSRC     (NSRC),
    .DCLR_BITS(DMA_CLR_BITS)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (soft_rst_o),
    .evt       (evt_i),
    .w1c_en    (int_we),
    .w1c_bits  (reg_wdata_i[NSRC-1:0]),
    .mask_we   (int_we),
    .mask_wdata(reg_wdata_i[REG_W-1:NSRC]),
    .dma_clr   (dma_clr_i),
    .stat_q    (stat_w),
    .mask_q    (mask_w),
    .irq_q     (irq_o)
  );

  always_comb begin
    srst_bit_d = srst_bit_q;
    frst_bit_d = frst_bit_q;
    if (sys_we) begin
      srst_bit_d = reg_wdata_i[SYS_SRST_BIT];
      frst_bit_d = reg_wdata_i[SYS_FRST_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_bit_q <= 1'b0;
      frst_bit_q <= 1'b0;
    end else if (sys_we) begin
      srst_bit_q <= srst_bit_d;
      frst_bit_q <= frst_bit_d;
    end
  end

  assign rst_req = {frst_bit_q, srst_bit_q};

  for (genvar g = 0; g < NRST; g++) begin : g_rst
    localparam int HOLD = (g == 0) ? SRST_MIN : FRST_MIN;
    rst_pulse_stretch #(.MIN_CYC(HOLD)) u_stretch (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (rst_req[g]),
      .pulse_q(rst_pulse[g])
    );
  end

  assign soft_rst_o = rst_pulse[0];
  assign fifo_rst_o = rst_pulse[1];

  always_comb begin
    if (reg_sel_e'(reg_sel_i) == SEL_INT) begin
      reg_rdata_o = {mask_w, stat_w};
    end else begin
      reg_rdata_o = '0;
      reg_rdata_o[SYS_SRST_BIT] = srst_bit_q;
      reg_rdata_o[SYS_FRST_BIT] = frst_bit_q;
      reg_rdata_o[SYS_CBL_BIT]  = cable_40w_i;
    end
  end
endmodule

// File: rtl/stor_irq_ctrl_chk.sv
module stor_irq_ctrl_chk #(
  parameter int SRST_MIN = 20,
  parameter int FRST_MIN = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_sel_i,
  input logic [15:0] reg_rdata_o,
  input logic [7:0]  evt_i,
  input logic        dma_clr_i,
  input logic        cable_40w_i,
  input logic        soft_rst_o,
  input logic        fifo_rst_o,
  input logic        irq_o,
  input logic [7:0]  stat_w,
  input logic [7:0]  mask_w
);
  logic [15:0] s_hi, f_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_hi <= '0;
      f_hi <= '0;
    end else begin
      s_hi <= soft_rst_o ? ((s_hi == 16'hFFFF) ? s_hi : s_hi + 16'd1) : 16'd0;
      f_hi <= fifo_rst_o ? ((f_hi == 16'hFFFF) ? f_hi : f_hi + 16'd1) : 16'd0;
    end
  end

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i && !soft_rst_o) |=> ((stat_w & $past(evt_i)) == $past(evt_i))); // R2
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |($past(stat_w) & ~$past(mask_w))); // R5
  AST_DMA_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_clr_i && !soft_rst_o) |=> (mask_w == 8'h00)); // R7
  AST_DMA_HOST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_clr_i && !soft_rst_o && !evt_i[0]) |=> !stat_w[0]); // R7
  AST_SRST_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_rst_o) |-> (32'(s_hi) >= SRST_MIN)); // R8
  AST_FRST_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fifo_rst_o) |-> (32'(f_hi) >= FRST_MIN)); // R9
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> (stat_w == 8'h00 && mask_w == 8'h00)); // R10
  AST_CABLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel_i |-> (reg_rdata_o[13] == cable_40w_i && reg_rdata_o[12:0] == 13'h0)); // R11
endmodule

bind stor_irq_ctrl stor_irq_ctrl_chk #(
  .SRST_MIN(SRST_MIN),
  .FRST_MIN(FRST_MIN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_sel_i  (reg_sel_i),
  .reg_rdata_o(reg_rdata_o),
  .evt_i      (evt_i),
  .dma_clr_i  (dma_clr_i),
  .cable_40w_i(cable_40w_i),
  .soft_rst_o (soft_rst_o),
  .fifo_rst_o (fifo_rst_o),
  .irq_o      (irq_o),
  .stat_w     (stat_w),
  .mask_w     (mask_w)
);

// File: tb/stor_irq_ctrl_bench.sv
`timescale 1ns/1ps
module stor_irq_ctrl_bench;
  localparam int SRST_MIN = 20;
  localparam int FRST_MIN = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic [7:0]  evt = 8'h0;
  logic        dma_clr = 1'b0;
  logic        cable = 1'b0;
  logic        srst, frst, irq;

  int checks = 0;
  int fails  = 0;
  int n_srst = 0;
  int n_frst = 0;
  logic [7:0] m_stat = 8'h0;
  logic [7:0] m_mask = 8'h0;

  always #4 clk = ~clk;

  stor_irq_ctrl #(.SRST_MIN(SRST_MIN), .FRST_MIN(FRST_MIN)) u_stor_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel_i(reg_sel), .reg_wr_i(reg_wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt), .dma_clr_i(dma_clr),
    .cable_40w_i(cable), .soft_rst_o(srst), .fifo_rst_o(frst), .irq_o(irq)
  );

  always @(negedge clk) begin
    if (srst) n_srst++;
    if (frst) n_frst++;
  end

  function automatic logic [7:0] nx_stat(logic [7:0] s, logic [7:0] ev, logic wr,
                                         logic [15:0] wd, logic dc);
    logic [7:0] c;
    c = wr ? wd[7:0] : 8'h00;
    if (dc) c = c | 8'h03;
    return (s & ~c) | ev;
  endfunction

  function automatic logic [7:0] nx_mask(logic [7:0] m, logic wr, logic [15:0] wd, logic dc);
    if (dc) return 8'h00;
    if (wr) return wd[15:8];
    return m;
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input logic [7:0] ev, input logic wr, input logic [15:0] wd,
                      input logic dc, input string tag);
    logic exp_irq;
    reg_sel = 1'b0; evt = ev; reg_wr = wr; wdata = wd; dma_clr = dc;
    exp_irq = |(m_stat & ~m_mask);
    m_stat  = nx_stat(m_stat, ev, wr, wd, dc);
    m_mask  = nx_mask(m_mask, wr, wd, dc);
    @(posedge clk); @(negedge clk);
    evt = 8'h0; reg_wr = 1'b0; dma_clr = 1'b0;
    chk(rdata, {m_mask, m_stat}, tag);
    chk({15'h0, irq}, {15'h0, exp_irq}, "R5 irq");
  endtask

  task automatic sys_write(input logic [15:0] wd);
    reg_sel = 1'b1; reg_wr = 1'b1; wdata = wd;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0;
  endtask

  // write bit, hold h cycles, clear; returns after the pulse ends
  task automatic pulse(input logic [15:0] val, input int h);
    n_srst = 0; n_frst = 0;
    sys_write(val);
    for (int k = 1; k < h; k++) begin
      @(posedge clk); @(negedge clk);
    end
    sys_write(16'h0000);
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rdata, 16'h0000, "R1 int reg");
    chk({13'h0, irq, srst, frst}, 16'h0, "R1 outputs");
    reg_sel = 1'b1; #1;
    chk(rdata, 16'h0000, "R1 sys reg");
    reg_sel = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdata, 16'h0000, "R1 after release");

    // R11 cable sense and write-ignore
    cable = 1'b1; reg_sel = 1'b1; #1;
    chk(rdata, 16'h2000, "R11 cable 40-wire");
    cable = 1'b0;
    sys_write(16'h3FFF);
    reg_sel = 1'b1; #1;
    chk(rdata, 16'h0000, "R11 write ignored");
    reg_sel = 1'b0;
    @(negedge clk);

    // R2 sticky, R5 masking
    step(8'h88, 1'b0, 16'h0, 1'b0, "R2 set bits 7,3");
    step(8'h00, 1'b0, 16'h0, 1'b0, "R2 sticky");
    step(8'h00, 1'b1, 16'hFF00, 1'b0, "R4 mask all");
    step(8'h00, 1'b0, 16'h0, 1'b0, "R5 all masked");
    // R3 clear only bit 7
    step(8'h00, 1'b1, 16'h0080, 1'b0, "R3 w1c bit 7");
    step(8'h00, 1'b0, 16'h0, 1'b0, "R3 bit 3 kept");
    // R6 event wins over clear
    step(8'h08, 1'b1, 16'h0008, 1'b0, "R6 event beats w1c");
    // R7 DMA clear
    step(8'h03, 1'b1, 16'h5500, 1'b0, "R7 setup");
    step(8'h01, 1'b1, 16'hAA00, 1'b1, "R7 dma clear with event");
    step(8'h00, 1'b0, 16'h0, 1'b1, "R7 dma clear");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [7:0]  ev;
      logic        wr;
      logic [15:0] wd;
      logic        dc;
      ev = 8'($urandom & $urandom & $urandom);
      wr = ($urandom % 10) < 3;
      wd = 16'($urandom);
      dc = ($urandom % 10) == 0;
      step(ev, wr, wd, dc, "R2 R3 R4 R6 R7 random");
    end

    // R8 soft reset pulse lengths
    pulse(16'h8000, 1);
    chk(16'(n_srst), 16'(SRST_MIN), "R8 short write stretched");
    pulse(16'h8000, 30);
    chk(16'(n_srst), 16'd30, "R8 long hold");
    m_stat = 8'h0; m_mask = 8'h0;
    // R9 FIFO reset pulse lengths
    pulse(16'h4000, 2);
    chk(16'(n_frst), 16'(FRST_MIN), "R9 short write stretched");
    pulse(16'h4000, 15);
    chk(16'(n_frst), 16'd15, "R9 long hold");

    // R10 activity ignored during soft reset
    step(8'hF0, 1'b1, 16'h0F00, 1'b0, "R10 setup");
    sys_write(16'h8000);
    sys_write(16'h0000);
    chk({15'h0, srst}, 16'h1, "R10 soft reset high");
    for (int k = 0; k < 5; k++) begin
      evt = 8'hFF; reg_wr = 1'b1; reg_sel = 1'b0; wdata = 16'hFF00; dma_clr = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(rdata, 16'h0000, "R10 held clear");
    end
    evt = 8'h0; reg_wr = 1'b0; dma_clr = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (srst) begin @(posedge clk); @(negedge clk); end
    end
    @(posedge clk); @(negedge clk);
    chk(rdata, 16'h0000, "R10 clean after reset");
    chk({15'h0, irq}, 16'h0, "R10 no irq");
    m_stat = 8'h0; m_mask = 8'h0;
    step(8'h04, 1'b0, 16'h0, 1'b0, "R2 events live again");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule